// File: doc/BRIEF.md
# Configurable memory-mapped register cell

This block is one cell of a small processor's internal register file. It watches a shared bus made of an address, a write strobe, a read strobe and write data. When the address matches the cell's own address parameter, the cell takes part in the access. At every other address it does nothing. Its bus read output is zero whenever the cell is not being read. Because of this, an integrator can merge the read outputs of many cells with a plain bitwise OR and needs no multiplexer.

Parameters fix how the cell behaves:

- **Hardware-side output.** It is either tied to zero or driven from a control flop that bus writes load.
- **What a read returns.** One of four choices:
  - the live hardware input word;
  - the control flop;
  - sticky error bits that hardware sets and software clears by writing ones;
  - a holding flop that loads the hardware input only while a capture enable is high.

A bit mask marks which bits exist. The cell also outputs a read-event strobe, and this strobe can drive the capture enable of a second cell. Used this way, reading the low half of a wide value freezes the high half, so the two halves read back as one coherent value.

Top module: `csr_cell`

## Requirements
- R1: The cell is selected only when `addr_i` equals `CELL_ADDR`; writes or reads at any other address leave its stored state, `hw_out_o` and its read data unchanged.
- R2: `rd_data_o` is all zeros in every cycle in which the cell is not selected with `rd_i` high.
- R3: With `OUT_MODE = OUT_ZERO`, `hw_out_o` is 0 at all times. With `OUT_MODE = OUT_LATCH`, a selected write loads `wdata_i & IMPL_MASK` into the control flop at the rising edge, and `hw_out_o` shows it from then on.
- R4: With `RD_MODE = RD_THRU`, a selected read returns `hw_in_i & IMPL_MASK` in the same cycle.
- R5: With `RD_MODE = RD_OUT`, a selected read returns the control flop's value, which is the last masked write.
- R6: With `RD_MODE = RD_W1C`, a hardware input bit that is high at a rising edge sets the matching sticky bit. A selected write clears each sticky bit whose write-data bit is 1. Write-data bits of 0 leave the sticky bits unchanged.
- R7: In `RD_W1C` mode, when a hardware set and a write-one clear hit the same bit at the same edge, the bit ends up set.
- R8: With `RD_MODE = RD_SNAP`, the holding flop loads `hw_in_i` only at edges where `cap_en_i` is high. Reads return the held value.
- R9: Bits that are 0 in `IMPL_MASK` are never stored and always read as 0, even when the hardware input or the write data has them high.
- R10: `rd_evt_o` is high in exactly the cycles in which the cell is selected with `rd_i` high. A write without a read, or a read at another address, keeps it low.
- R11: While `rst_ni` is low, every stored bit (control, sticky and held) is 0, and it stays 0 until the first rising edge after release. Reset takes effect asynchronously.
- R12: When the `rd_evt_o` of a low-half cell drives the `cap_en_i` of a high-half `RD_SNAP` cell, a read of the high half returns the value the high input had during the most recent low-half read, whatever happened to the input since then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| wr_i | input | 1 | Bus write strobe, active high |
| rd_i | input | 1 | Bus read strobe, active high |
| wdata_i | input | DATA_W | Bus write data |
| rd_data_o | output | DATA_W | Read data; zero unless this cell is read |
| hw_in_i | input | DATA_W | Hardware-side input word (status, error pulses or capture source) |
| cap_en_i | input | 1 | Capture enable for the holding flop |
| hw_out_o | output | DATA_W | Hardware-side output word (control flop or zero) |
| rd_evt_o | output | 1 | Strobe, high while the cell is read |

## Verification
Two functions can fall in the same cycle on a sticky bit: a hardware error pulse setting it and a bus write of one clearing it. The bench provokes this by raising an error input bit during the same cycle as a write that has a 1 in that bit. It then reads the cell on the next cycle and expects the bit to be set. Two more checks surround that case. A write of one with no pulse, made before and after it, must clear the bit, and this shows that the result comes from priority and not from a write path that does nothing. The pairing of a low-half read with a high-half capture is judged in the same way: the high input changes after the low read, and the bench expects the old value back until the next low read.

// File: rtl/csr_cell_pkg.sv
package csr_cell_pkg;

  // Hardware-side output behaviour.
  typedef enum logic {
    OUT_ZERO  = 1'b0,
    OUT_LATCH = 1'b1
  } out_mode_e;

  // Source of the bus read value.
  typedef enum logic [1:0] {
    RD_THRU = 2'd0,
    RD_OUT  = 2'd1,
    RD_W1C  = 2'd2,
    RD_SNAP = 2'd3
  } rd_mode_e;

endpackage

// File: rtl/csr_cell_decode.sv
module csr_cell_decode #(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CELL_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);

  logic sel;

  always_comb begin
    sel      = (addr_i == CELL_ADDR);
    wr_hit_o = sel & wr_i;
    rd_hit_o = sel & rd_i;
  end

endmodule

// File: rtl/csr_cell_outreg.sv
module csr_cell_outreg
  import csr_cell_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1,
  parameter out_mode_e         OUT_MODE  = OUT_LATCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] out_q_o
);

  if (OUT_MODE == OUT_LATCH) begin : g_latch
    logic [DATA_W-1:0] ctl_d, ctl_q;
    logic              ctl_en;

    always_comb begin
      ctl_en = wr_hit_i;
      ctl_d  = wdata_i & IMPL_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ctl_q <= '0;
      else if (ctl_en) ctl_q <= ctl_d;
    end

    assign out_q_o = ctl_q;

    // R1: no selected write, no change of the control flop
    p_ctl_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit_i |=> $stable(out_q_o));
    // R3: a selected write shows up masked after the edge
    p_ctl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit_i |=> (out_q_o == ($past(wdata_i) & IMPL_MASK)));
  end else begin : g_zero
    logic unused_zero;
    assign unused_zero = ^{clk_i, rst_ni, wr_hit_i, wdata_i};
    assign out_q_o     = '0;
  end

endmodule

// File: rtl/csr_cell_store.sv
module csr_cell_store
  import csr_cell_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1,
  parameter rd_mode_e          RD_MODE   = RD_THRU
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] hw_in_i,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] out_q_i,
  output logic [DATA_W-1:0] rd_val_o
);

  logic unused_store;
  assign unused_store = ^{clk_i, rst_ni, wr_hit_i, wdata_i, hw_in_i, cap_en_i, out_q_i};

  if (RD_MODE == RD_THRU) begin : g_thru
    assign rd_val_o = hw_in_i & IMPL_MASK;

  end else if (RD_MODE == RD_OUT) begin : g_out
    assign rd_val_o = out_q_i & IMPL_MASK;

  end else if (RD_MODE == RD_W1C) begin : g_w1c
    logic [DATA_W-1:0] stk_d, stk_q, clr_vec;

    // Set is OR-ed in after the clear, so a same-edge set survives.
    always_comb begin
      clr_vec = wr_hit_i ? wdata_i : '0;
      stk_d   = ((stk_q & ~clr_vec) | hw_in_i) & IMPL_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stk_q <= '0;
      else         stk_q <= stk_d;
    end

    assign rd_val_o = stk_q;

    // R6, R7: every implemented input bit high at an edge is set afterwards
    p_stk_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(hw_in_i & IMPL_MASK)) |=>
        ((stk_q & $past(hw_in_i & IMPL_MASK)) == $past(hw_in_i & IMPL_MASK)));
    // R6: without a selected write no sticky bit falls
    p_stk_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit_i |=> ((stk_q & $past(stk_q)) == $past(stk_q)));
    // R9: unimplemented bits never stored
    p_stk_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stk_q & ~IMPL_MASK) == '0);

  end else begin : g_snap
    logic [DATA_W-1:0] hold_d, hold_q;
    logic              hold_en;

    always_comb begin
      hold_en = cap_en_i;
      hold_d  = hw_in_i & IMPL_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hold_q <= '0;
      else if (hold_en) hold_q <= hold_d;
    end

    assign rd_val_o = hold_q;

    // R8: the held word only moves on a capture edge
    p_snap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_en_i |=> $stable(hold_q));
  end

endmodule

// File: rtl/csr_cell.sv
module csr_cell
  import csr_cell_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CELL_ADDR = '0,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1,
  parameter out_mode_e         OUT_MODE  = OUT_LATCH,
  parameter rd_mode_e          RD_MODE   = RD_OUT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] hw_in_i,
  input  logic              cap_en_i,
  output logic [DATA_W-1:0] hw_out_o,
  output logic              rd_evt_o
);

  logic              wr_hit, rd_hit;
  logic [DATA_W-1:0] ctl_q, rd_val;

  csr_cell_decode #(
    .ADDR_W   (ADDR_W),
    .CELL_ADDR(CELL_ADDR)
  ) i_decode (
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  csr_cell_outreg #(
    .DATA_W   (DATA_W),
    .IMPL_MASK(IMPL_MASK),
    .OUT_MODE (OUT_MODE)
  ) i_outreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hit_i(wr_hit),
    .wdata_i (wdata_i),
    .out_q_o (ctl_q)
  );

  csr_cell_store #(
    .DATA_W   (DATA_W),
    .IMPL_MASK(IMPL_MASK),
    .RD_MODE  (RD_MODE)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hit_i(wr_hit),
    .wdata_i (wdata_i),
    .hw_in_i (hw_in_i),
    .cap_en_i(cap_en_i),
    .out_q_i (ctl_q),
    .rd_val_o(rd_val)
  );

  always_comb begin
    rd_data_o = rd_hit ? rd_val : '0;
    hw_out_o  = ctl_q;
    rd_evt_o  = rd_hit;
  end

  // R2: idle read bus unless this cell is read
  p_rd_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && (addr_i == CELL_ADDR)) |-> (rd_data_o == '0));
  // R9: unimplemented bits read as zero
  p_rd_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~IMPL_MASK) == '0);
  // R10: the read event needs a bus read
  p_evt_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_o |-> rd_i);
  // R10: the read event needs this address
  p_evt_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != CELL_ADDR) |-> !rd_evt_o);

endmodule

// File: tb/test_csr_cell.sv
module test_csr_cell;
  import csr_cell_pkg::*;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0]  a;
    logic        w;
    logic        r;
    logic [15:0] d;
    logic [15:0] e;
  } vec_t;

  // Bus table against ctrl (addr 2, mask 00FF) and status (addr 1, mask 0007, input ABCD)
  localparam vec_t TBL [11] = '{
    '{4'd2, 1'b1, 1'b0, 16'h1234, 16'h0000},
    '{4'd2, 1'b0, 1'b1, 16'h0000, 16'h0034},
    '{4'd3, 1'b1, 1'b0, 16'h00FF, 16'h0000},
    '{4'd2, 1'b0, 1'b1, 16'h0000, 16'h0034},
    '{4'd1, 1'b0, 1'b1, 16'h0000, 16'h0005},
    '{4'd1, 1'b1, 1'b0, 16'hFFFF, 16'h0000},
    '{4'd2, 1'b0, 1'b1, 16'h0000, 16'h0034},
    '{4'd6, 1'b0, 1'b1, 16'h0000, 16'h0000},
    '{4'd2, 1'b1, 1'b0, 16'h00A5, 16'h0000},
    '{4'd2, 1'b0, 1'b1, 16'h0000, 16'h00A5},
    '{4'd2, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [15:0] wdata;
  logic [15:0] st_in, err_in, lo_in, hi_in;
  logic [15:0] rd_ctl, rd_st, rd_err, rd_lo, rd_hi, rd_bus;
  logic [15:0] ctl_out, st_out, err_out, lo_out, hi_out;
  logic        ev_ctl, ev_st, ev_err, ev_lo, ev_hi;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign rd_bus = rd_ctl | rd_st | rd_err | rd_lo | rd_hi;

  csr_cell #(.CELL_ADDR(4'd2), .IMPL_MASK(16'h00FF), .OUT_MODE(OUT_LATCH), .RD_MODE(RD_OUT))
  i_csr_cell (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rd_data_o(rd_ctl), .hw_in_i(16'h0000), .cap_en_i(1'b0), .hw_out_o(ctl_out), .rd_evt_o(ev_ctl));

  csr_cell #(.CELL_ADDR(4'd1), .IMPL_MASK(16'h0007), .OUT_MODE(OUT_ZERO), .RD_MODE(RD_THRU))
  i_csr_cell_st (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rd_data_o(rd_st), .hw_in_i(st_in), .cap_en_i(1'b0), .hw_out_o(st_out), .rd_evt_o(ev_st));

  csr_cell #(.CELL_ADDR(4'd4), .IMPL_MASK(16'h0FFF), .OUT_MODE(OUT_ZERO), .RD_MODE(RD_W1C))
  i_csr_cell_err (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rd_data_o(rd_err), .hw_in_i(err_in), .cap_en_i(1'b0), .hw_out_o(err_out), .rd_evt_o(ev_err));

  csr_cell #(.CELL_ADDR(4'd8), .IMPL_MASK(16'hFFFF), .OUT_MODE(OUT_LATCH), .RD_MODE(RD_THRU))
  i_csr_cell_lo (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rd_data_o(rd_lo), .hw_in_i(lo_in), .cap_en_i(1'b0), .hw_out_o(lo_out), .rd_evt_o(ev_lo));

  csr_cell #(.CELL_ADDR(4'd9), .IMPL_MASK(16'hFFFF), .OUT_MODE(OUT_LATCH), .RD_MODE(RD_SNAP))
  i_csr_cell_hi (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rd_data_o(rd_hi), .hw_in_i(hi_in), .cap_en_i(ev_lo), .hw_out_o(hi_out), .rd_evt_o(ev_hi));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one bus cycle at the falling edge; combinational results settle 1 time unit later.
  task automatic cyc(input logic [3:0] a, input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    st_in = 16'hABCD; err_in = '0; lo_in = '0; hi_in = '0;
    repeat (3) @(posedge clk);
    // R11: reset state
    cyc(4'd2, 1'b1, 1'b1, 16'hFFFF);
    chk("R11 ctrl read in reset", rd_bus, 16'h0000);
    cyc(4'd0, 1'b0, 1'b0, 16'h0000);
    chk("R11 ctrl out in reset", ctl_out, 16'h0000);
    chk("R11 lo out in reset", lo_out, 16'h0000);
    rst_n = 1'b1;

    // Table walk: R1 R2 R4 R5 R9
    foreach (TBL[i]) begin
      cyc(TBL[i].a, TBL[i].w, TBL[i].r, TBL[i].d);
      chk($sformatf("R1/R2/R4/R5 table row %0d", i), rd_bus, TBL[i].e);
    end
    chk("R3 ctrl latched out", ctl_out, 16'h00A5);
    chk("R3 zero-mode out", st_out, 16'h0000);

    // R3: write then hardware output
    cyc(4'd8, 1'b1, 1'b0, 16'hBEEF);
    chk("R10 write gives no event", {15'd0, ev_lo}, 16'h0000);
    cyc(4'd0, 1'b0, 1'b0, 16'h0000);
    chk("R3 lo out after write", lo_out, 16'hBEEF);

    // R6: sticky set, write-0 keep, write-1 clear
    err_in = 16'h0011;
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    err_in = 16'h0000;
    chk("R6 sticky set", rd_bus, 16'h0011);
    cyc(4'd4, 1'b1, 1'b0, 16'h0000);
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    chk("R6 write zero keeps", rd_bus, 16'h0011);
    cyc(4'd4, 1'b1, 1'b0, 16'h0001);
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    chk("R6 write one clears", rd_bus, 16'h0010);
    // R7: set and clear on the same edge
    cyc(4'd4, 1'b1, 1'b0, 16'h0010);
    err_in = 16'h0010;
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    err_in = 16'h0000;
    chk("R7 set wins over clear", rd_bus, 16'h0010);
    cyc(4'd4, 1'b1, 1'b0, 16'h0010);
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    chk("R7 plain clear after", rd_bus, 16'h0000);
    // R9: unimplemented error bits
    err_in = 16'hF000;
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    err_in = 16'h0000;
    chk("R9 masked sticky bits", rd_bus, 16'h0000);

    // R8 R10 R12: coherent wide read
    lo_in = 16'h1111; hi_in = 16'h2222;
    cyc(4'd8, 1'b0, 1'b1, 16'h0000);
    chk("R12 low half read", rd_bus, 16'h1111);
    chk("R10 event on read", {15'd0, ev_lo}, 16'h0001);
    cyc(4'd9, 1'b0, 1'b1, 16'h0000);
    chk("R12 high half frozen", rd_bus, 16'h2222);
    chk("R10 other address no event", {15'd0, ev_lo}, 16'h0000);
    hi_in = 16'h3333;
    cyc(4'd9, 1'b0, 1'b1, 16'h0000);
    chk("R8 no capture without enable", rd_bus, 16'h2222);
    cyc(4'd8, 1'b0, 1'b1, 16'h0000);
    cyc(4'd9, 1'b0, 1'b1, 16'h0000);
    chk("R8 capture on low read", rd_bus, 16'h3333);

    // R11: reset in the middle of operation
    err_in = 16'h0003;
    cyc(4'd0, 1'b0, 1'b0, 16'h0000);
    err_in = 16'h0000;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 ctrl out async clear", ctl_out, 16'h0000);
    chk("R11 lo out async clear", lo_out, 16'h0000);
    cyc(4'd4, 1'b0, 1'b1, 16'h0000);
    chk("R11 sticky cleared", rd_bus, 16'h0000);
    cyc(4'd9, 1'b0, 1'b1, 16'h0000);
    chk("R11 snapshot cleared", rd_bus, 16'h0000);
    cyc(4'd2, 1'b0, 1'b1, 16'h0000);
    chk("R11 ctrl read cleared", rd_bus, 16'h0000);
    rst_n = 1'b1;
    cyc(4'd0, 1'b0, 1'b0, 16'h0000);

    finish_run();
  end

endmodule